// File: doc/BRIEF.md
# Cache Partition Size Selector

This block chooses, once per measurement interval, how many ways of a 4-way set-associative cache make up the fast primary partition. The remaining ways make up the slower secondary partition. The cache reports one event per lookup. A hit event carries the recency rank of the hitting line in its set, where rank 0 is the most recently used line and rank 3 is the least recently used. A miss event carries no rank. The block keeps one saturating histogram counter per rank and one counter for misses. From these counters it can work out the hits and misses that any partition size would have produced, without running the cache at that size.

A retire pulse input advances an interval counter. When the interval ends, a small controller steps through the four candidate sizes, one per cycle. For each size the datapath forms a weighted access cost. The weight is a per-size cycle time taken from an input, so that the clock rate each size allows is included in the comparison. The cheapest size is kept, and the smaller size wins a tie. When the evaluation finishes, the result is written to the output register with a one-cycle valid pulse and the counters are cleared. While the evaluation runs, the ready output is low and the cache must hold any event it is offering.

Top module: `way_part_selector`

## Requirements
- R1: During and after reset, selSize is 0 (one fast way), selValid is 0 and accReady is 1.
- R2: An event is taken only in a cycle with accValid and accReady both high. A taken hit adds one to the counter for the rank on accPos (0 = most recent, 3 = least recent). A taken miss (accHit low) adds one to the miss counter.
- R3: selSize value k means k+1 fast ways. For index k, fast hits are the counts at ranks 0..k and slow hits are the counts at ranks k+1..3. The cost is w_k*(fast*LAT_A + slow*(LAT_A+LB_k) + misses*MISS_PEN). LB_k is LAT_B1, LAT_B2 or LAT_B3 for k = 0, 1 or 2 (defaults 8, 5, 2). For k = 3 there is no slow partition. w_k is sizeWeight[k*WT_W +: WT_W].
- R4: The selected index is the one with the lowest cost. When costs are equal, the smaller index is selected.
- R5: An interval ends on the INTERVAL-th retirePulse since reset or since the previous end. Fewer pulses start no evaluation.
- R6: accReady goes low in the cycle after the interval ends and stays low for exactly 5 cycles. Events offered while it is low are not counted.
- R7: selValid is high for exactly one cycle per evaluation, in the same cycle that accReady returns high. selSize changes only in a cycle where selValid is high.
- R8: All counters are cleared when the result is committed, so each decision depends only on the events of its own interval.
- R9: Each counter saturates at 2^CNT_W-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | Cache lookup event present |
| accHit | input | 1 | 1 = hit, 0 = miss |
| accPos | input | 2 | Recency rank of the hitting line |
| retirePulse | input | 1 | One instruction retired |
| sizeWeight | input | 4*WT_W | Per-size cycle-time weights, index k at bits k*WT_W |
| accReady | output | 1 | Block can take an event this cycle |
| selSize | output | 2 | Chosen fast-partition size minus one |
| selValid | output | 1 | One-cycle pulse when a new choice is written |

## Verification
The bound checker watches the handshake timing on every cycle. It checks that accReady drops only right after a retire pulse, that the low window is never longer than five cycles, and that accReady comes back together with the valid pulse. It also checks that the valid pulse lasts one cycle and that the selected size never moves without it. The choice itself can only be shown by the bench's directed intervals. These cover ties, every rank, the miss penalty, the per-size weights, counter clearing, events offered during evaluation that must be dropped, and a counter pushed past its saturation limit where wrapping would flip the answer.

// File: rtl/wps_pkg.sv
package wps_pkg;
  localparam int NUM_WAYS = 4;
  localparam int POS_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EVAL   = 2'd1,
    ST_COMMIT = 2'd2
  } ctrlState_t;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic             countEn;
    logic             evalEn;
    logic             evalFirst;
    logic [POS_W-1:0] evalIdx;
    logic             commit;
  } dpStrobe_t;
endpackage

// File: rtl/wps_ctrl.sv
module wps_ctrl
  import wps_pkg::*;
#(
  parameter int INTERVAL = 15000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       retirePulse,
  output dpStrobe_t  strobe,
  output logic       accReady
);
  localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [IW-1:0] LAST = IW'(INTERVAL - 1);

  logic [IW-1:0]    intCnt;
  logic             boundary;
  ctrlState_t       state;
  logic [POS_W-1:0] idxQ;

  assign boundary = retirePulse && (intCnt == LAST);

  // Retire counter runs in every state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            intCnt <= '0;
    else if (retirePulse) intCnt <= (intCnt == LAST) ? '0 : intCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idxQ  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (boundary) begin
          state <= ST_EVAL;
          idxQ  <= '0;
        end
        ST_EVAL: begin
          if (idxQ == POS_W'(NUM_WAYS - 1)) state <= ST_COMMIT;
          idxQ <= idxQ + 1'b1;
        end
        ST_COMMIT: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.countEn   = (state == ST_IDLE);
    strobe.evalEn    = (state == ST_EVAL);
    strobe.evalFirst = (idxQ == '0);
    strobe.evalIdx   = idxQ;
    strobe.commit    = (state == ST_COMMIT);
    accReady         = (state == ST_IDLE);
  end
endmodule

// File: rtl/wps_datapath.sv
module wps_datapath
  import wps_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int WT_W     = 8,
  parameter int LAT_A    = 2,
  parameter int LAT_B1   = 8,
  parameter int LAT_B2   = 5,
  parameter int LAT_B3   = 2,
  parameter int MISS_PEN = 20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     accValid,
  input  logic                     accHit,
  input  logic [POS_W-1:0]         accPos,
  input  logic [NUM_WAYS*WT_W-1:0] sizeWeight,
  input  dpStrobe_t                strobe,
  output logic [POS_W-1:0]         selSize,
  output logic                     selValid
);
  localparam int LAT_W  = 8;
  localparam int SUM_W  = CNT_W + 2;
  localparam int COST_W = SUM_W + LAT_W + 2 + WT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  hist [NUM_WAYS];
  logic [CNT_W-1:0]  missCnt;
  logic [COST_W-1:0] cost [NUM_WAYS];
  logic [COST_W-1:0] curCost;
  logic [COST_W-1:0] bestCost;
  logic [POS_W-1:0]  bestIdx;
  logic              take;

  assign take = accValid && strobe.countEn;

  // One saturating histogram counter per recency rank
  for (genvar p = 0; p < NUM_WAYS; p++) begin : g_hist
    logic [CNT_W-1:0] cntQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cntQ <= '0;
      else if (strobe.commit)
        cntQ <= '0;
      else if (take && accHit && (accPos == POS_W'(p)) && (cntQ != CNT_MAX))
        cntQ <= cntQ + 1'b1;
    end
    assign hist[p] = cntQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      missCnt <= '0;
    else if (strobe.commit)
      missCnt <= '0;
    else if (take && !accHit && (missCnt != CNT_MAX))
      missCnt <= missCnt + 1'b1;
  end

  // Cost for each candidate size
  for (genvar k = 0; k < NUM_WAYS; k++) begin : g_cost
    localparam int LB = (k == 0) ? LAT_B1 : (k == 1) ? LAT_B2 : (k == 2) ? LAT_B3 : 0;
    logic [SUM_W-1:0]  fastSum;
    logic [SUM_W-1:0]  slowSum;
    logic [COST_W-1:0] rawCost;
    always_comb begin
      fastSum = '0;
      slowSum = '0;
      for (int p = 0; p < NUM_WAYS; p++) begin
        if (p <= k) fastSum = fastSum + SUM_W'(hist[p]);
        else        slowSum = slowSum + SUM_W'(hist[p]);
      end
      rawCost = COST_W'(fastSum) * COST_W'(LAT_A)
              + COST_W'(slowSum) * COST_W'(LAT_A + LB)
              + COST_W'(missCnt) * COST_W'(MISS_PEN);
    end
    assign cost[k] = rawCost * COST_W'(sizeWeight[k*WT_W +: WT_W]);
  end

  assign curCost = cost[strobe.evalIdx];

  // Sequential minimum search, strict compare keeps the smaller size on ties
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestCost <= '0;
      bestIdx  <= '0;
    end else if (strobe.evalEn && (strobe.evalFirst || (curCost < bestCost))) begin
      bestCost <= curCost;
      bestIdx  <= strobe.evalIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selSize  <= '0;
      selValid <= 1'b0;
    end else begin
      selValid <= strobe.commit;
      if (strobe.commit) selSize <= bestIdx;
    end
  end
endmodule

// File: rtl/way_part_selector.sv
module way_part_selector
  import wps_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int WT_W     = 8,
  parameter int INTERVAL = 15000,
  parameter int LAT_A    = 2,
  parameter int LAT_B1   = 8,
  parameter int LAT_B2   = 5,
  parameter int LAT_B3   = 2,
  parameter int MISS_PEN = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                accValid,
  input  logic                accHit,
  input  logic [1:0]          accPos,
  input  logic                retirePulse,
  input  logic [4*WT_W-1:0]   sizeWeight,
  output logic                accReady,
  output logic [1:0]          selSize,
  output logic                selValid
);
  dpStrobe_t strobe;

  wps_ctrl #(.INTERVAL(INTERVAL)) ctrl_i (
    .clk(clk), .rstN(rstN), .retirePulse(retirePulse),
    .strobe(strobe), .accReady(accReady)
  );

  wps_datapath #(
    .CNT_W(CNT_W), .WT_W(WT_W), .LAT_A(LAT_A), .LAT_B1(LAT_B1),
    .LAT_B2(LAT_B2), .LAT_B3(LAT_B3), .MISS_PEN(MISS_PEN)
  ) dp_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accHit(accHit),
    .accPos(accPos), .sizeWeight(sizeWeight), .strobe(strobe),
    .selSize(selSize), .selValid(selValid)
  );
endmodule

// File: rtl/wps_checker.sv
module wps_checker (
  input logic       clk,
  input logic       rstN,
  input logic       retirePulse,
  input logic       accReady,
  input logic [1:0] selSize,
  input logic       selValid
);
  logic [2:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          lowRun <= '0;
    else if (!accReady) lowRun <= (lowRun == 3'd7) ? lowRun : lowRun + 1'b1;
    else                lowRun <= '0;
  end

  a_r5_ready_fall_on_retire: assert property (@(posedge clk) disable iff (!rstN)
    $fell(accReady) |-> $past(retirePulse));

  a_r6_ready_low_bounded: assert property (@(posedge clk) disable iff (!rstN)
    !accReady |-> (lowRun < 3'd5));

  a_r6_valid_after_stall: assert property (@(posedge clk) disable iff (!rstN)
    selValid |-> $past(!accReady));

  a_r7_ready_back_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accReady) |-> selValid);

  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    selValid |=> !selValid);

  a_r7_sel_only_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    (selSize != $past(selSize)) |-> selValid);
endmodule

bind way_part_selector wps_checker chk_i (
  .clk(clk), .rstN(rstN), .retirePulse(retirePulse), .accReady(accReady),
  .selSize(selSize), .selValid(selValid)
);

// File: tb/way_part_selector_tb_top.sv
module way_part_selector_tb_top;
  localparam int CNT_W    = 4;
  localparam int WT_W     = 8;
  localparam int INTERVAL = 8;
  localparam int LAT_A    = 2;
  localparam int MISS_PEN = 20;
  localparam int CMAX     = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              accValid = 1'b0;
  logic              accHit = 1'b0;
  logic [1:0]        accPos = '0;
  logic              retirePulse = 1'b0;
  logic [4*WT_W-1:0] sizeWeight = {8'd1, 8'd1, 8'd1, 8'd1};
  logic              accReady;
  logic [1:0]        selSize;
  logic              selValid;

  int checkCnt = 0;
  int failCnt  = 0;
  int mHist [4];
  int mMiss;

  always #10 clk = ~clk;

  way_part_selector #(
    .CNT_W(CNT_W), .WT_W(WT_W), .INTERVAL(INTERVAL), .LAT_A(LAT_A),
    .LAT_B1(8), .LAT_B2(5), .LAT_B3(2), .MISS_PEN(MISS_PEN)
  ) dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accHit(accHit),
    .accPos(accPos), .retirePulse(retirePulse), .sizeWeight(sizeWeight),
    .accReady(accReady), .selSize(selSize), .selValid(selValid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void clearModel();
    for (int p = 0; p < 4; p++) mHist[p] = 0;
    mMiss = 0;
  endfunction

  // Cheapest size index from the modelled counts, following R3 and R4
  function automatic int modelPick();
    longint best = 0;
    int     bestK = 0;
    for (int k = 0; k < 4; k++) begin
      longint fastS = 0, slowS = 0, c;
      int lb = (k == 0) ? 8 : (k == 1) ? 5 : (k == 2) ? 2 : 0;
      for (int p = 0; p < 4; p++) begin
        if (p <= k) fastS += mHist[p];
        else        slowS += mHist[p];
      end
      c = longint'(sizeWeight[k*WT_W +: WT_W]) *
          (fastS * LAT_A + slowS * (LAT_A + lb) + longint'(mMiss) * MISS_PEN);
      if (k == 0 || c < best) begin
        best  = c;
        bestK = k;
      end
    end
    return bestK;
  endfunction

  // R2, R9: drive n events, one per cycle, while ready is high
  task automatic doAcc(input bit hit, input int pos, input int n);
    for (int i = 0; i < n; i++) begin
      accValid = 1'b1;
      accHit   = hit;
      accPos   = 2'(pos);
      if (hit) begin if (mHist[pos] < CMAX) mHist[pos]++; end
      else     begin if (mMiss < CMAX) mMiss++; end
      @(negedge clk);
    end
    accValid = 1'b0;
  endtask

  // Ends an interval with the given number of retire pulses, then checks R4/R6/R7
  task automatic endInterval(input string tag, input bit stray, input int pulses);
    int lowN = 0;
    int waited = 0;
    int exp;
    for (int i = 0; i < pulses; i++) begin
      retirePulse = 1'b1;
      @(negedge clk);
    end
    retirePulse = 1'b0;
    while (!selValid && waited < 50) begin
      if (!accReady) lowN++;
      if (stray) begin // R6: offered while stalled, must be dropped
        accValid = 1'b1; accHit = 1'b1; accPos = 2'd3;
      end
      @(negedge clk);
      waited++;
    end
    accValid = 1'b0;
    exp = modelPick();
    chk(selValid == 1'b1, "R7", {tag, " valid pulse seen"}, selValid, 1);
    chk(lowN == 5, "R6", {tag, " ready low cycles"}, lowN, 5);
    chk(selSize == 2'(exp), "R4", {tag, " selected size"}, selSize, exp);
    chk(accReady == 1'b1, "R7", {tag, " ready back with valid"}, accReady, 1);
    @(negedge clk);
    chk(selValid == 1'b0, "R7", {tag, " valid one cycle"}, selValid, 0);
    clearModel(); // R8: counters cleared at commit
  endtask

  task automatic t_reset();
    chk(selSize == 2'd0, "R1", "reset selSize", selSize, 0);
    chk(selValid == 1'b0, "R1", "reset selValid", selValid, 0);
    chk(accReady == 1'b1, "R1", "reset accReady", accReady, 1);
  endtask

  task automatic t_interval_count(); // R5
    int seen = 0;
    for (int i = 0; i < INTERVAL - 1; i++) begin
      retirePulse = 1'b1;
      @(negedge clk);
    end
    retirePulse = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (selValid || !accReady) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R5", "no evaluation before INTERVAL pulses", seen, 0);
    endInterval("R5 last pulse", 1'b0, 1);
  endtask

  task automatic t_tie_rank0(); // R4 tie, R2 rank 0
    sizeWeight = {8'd1, 8'd1, 8'd1, 8'd1};
    doAcc(1'b1, 0, 10);
    endInterval("R4 tie rank0", 1'b0, INTERVAL);
  endtask

  task automatic t_rank3_stray(); // R3 rank 3, stray events for R6
    doAcc(1'b1, 3, 10);
    endInterval("R3 rank3", 1'b1, INTERVAL);
  endtask

  task automatic t_cleared(); // R8 and R6: old and stray rank3 counts gone
    doAcc(1'b1, 0, 5);
    endInterval("R8 cleared", 1'b0, INTERVAL);
  endtask

  task automatic t_rank1(); // R2 rank 1, tie among sizes 1..3
    doAcc(1'b1, 1, 10);
    endInterval("R2 rank1", 1'b0, INTERVAL);
  endtask

  task automatic t_weights(); // R3 weights shift the choice
    sizeWeight = {8'd4, 8'd1, 8'd1, 8'd1};
    doAcc(1'b1, 3, 10);
    endInterval("R3 weights", 1'b0, INTERVAL);
  endtask

  task automatic t_misses(); // R3 miss term with weights
    sizeWeight = {8'd2, 8'd2, 8'd1, 8'd1};
    doAcc(1'b1, 3, 4);
    doAcc(1'b0, 0, 10);
    endInterval("R3 misses", 1'b0, INTERVAL);
  endtask

  task automatic t_saturate(); // R9: wrapping would pick index 3
    sizeWeight = {8'd2, 8'd15, 8'd15, 8'd1};
    doAcc(1'b1, 0, 17);
    doAcc(1'b1, 3, 2);
    endInterval("R9 saturate", 1'b0, INTERVAL);
    chk(mHist[0] == 0, "R9", "model cleared", mHist[0], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    clearModel();
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_interval_count();
    t_tie_rank0();
    t_rank3_stray();
    t_cleared();
    t_rank1();
    t_weights();
    t_misses();
    t_saturate();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule